// File: doc/BRIEF.md
# Three-Byte SPI Pressure Reader

This block is an SPI master that fetches a single pressure sample from a sensor slave each time it is asked to. A one-cycle `start` pulse while the block is idle drops the slave select, runs a fixed read-only frame of 24 serial clocks in mode 0 (clock idle low, data sampled on the rising edge), and keeps the master-out line high for the whole frame, so nothing is written to the slave. The serial clock half-period is a whole number of system clocks set by the `HALF_DIV` parameter.

Three bytes arrive most significant bit first. The first byte is a filler that a healthy slave sends as all ones; it carries no pressure data. It is compared against 0xFF, and a mismatch raises `filler_err`, but the pressure is still reported. The last two bytes form a 16-bit word whose top bit is a don't-care, and its lower 15 bits are the pressure result.

The result leaves on a valid/ready interface. `res_valid` rises when the slave select is released. While `res_valid` is high and `res_ready` is low, the result is held unchanged and the block stays busy, so a slow consumer stalls new frames rather than losing data. The result is consumed in the cycle where both are high. `start` and `busy` are plain control pins.

Top module: `spi_press_reader`

## Requirements
- R1: A `start` pulse sampled while `busy` is low drops `ss_n` and raises `busy` after that clock edge. A `start` sampled while `busy` is high, including the handshake cycle, has no effect.
- R2: `sck` is low whenever `ss_n` is high. Each frame has exactly 24 rising `sck` edges under one continuous low period of `ss_n`.
- R3: Each `sck` level lasts `HALF_DIV` system clocks. The first rising edge comes `HALF_DIV` clocks after `ss_n` falls, and `ss_n` rises `HALF_DIV` clocks after the last falling edge. A full frame occupies 49 × `HALF_DIV` clocks.
- R4: `mosi` is 1 at all times.
- R5: `miso` is sampled when `sck` rises, and the first bit received is the most significant. `pressure` equals bits 14..0 of the last 16 bits received. Bit 15 of those 16 bits has no effect on any output.
- R6: `filler_err` is 1 exactly when the first 8 bits received differ from 8'hFF. `pressure` is reported in either case.
- R7: `res_valid` rises in the same cycle that `ss_n` rises. While `res_valid` is 1 and `res_ready` is 0, `pressure` and `filler_err` hold steady and `busy` stays 1. In a cycle where `res_valid` and `res_ready` are both 1, the result is consumed: `res_valid` and `busy` are 0 after that edge.
- R8: During and after reset, `ss_n` is 1, `sck` is 0, `busy` is 0 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one read frame (only acted on while idle) |
| busy | output | 1 | Frame in progress or result not yet consumed |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer accepts the result |
| pressure | output | 15 | Pressure field of the last frame |
| filler_err | output | 1 | First received byte was not 0xFF |
| sck | output | 1 | Serial clock to the slave, idles low |
| ss_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Master-out data, held high |
| miso | input | 1 | Slave-out data |

## Verification
On every cycle, the assertions check the framing rules: the clock is quiet whenever the select is high, the result appears together with the release of the select, a stalled result holds still, and an in-flight frame never loses `busy`. A counter in the checker also confirms that exactly 24 rising edges fall inside each select window. The exact half-period timing, the bit order, the removal of the don't-care bit, the filler comparison and the ignoring of extra start pulses depend on the data the slave sends. Only the bench's scenarios show these, by comparing every output against a behavioural timeline for several frame patterns and consumer stalls.

// File: rtl/spi_press_pkg.sv
package spi_press_pkg;
  typedef enum logic [2:0] {
    RD_IDLE,
    RD_SETUP,
    RD_HIGH,
    RD_LOW,
    RD_HOLD,
    RD_VALID
  } rd_state_t;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_rx_shift.sv
module spi_rx_shift #(
  parameter int FRAME_BITS = 24,
  parameter int HEAD_W     = 8,
  parameter int TAIL_W     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HEAD_W-1:0] head,
  output logic [TAIL_W-1:0] tail
);
  logic [FRAME_BITS-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) sreg <= '0;
    else if (shift_en) sreg <= {sreg[FRAME_BITS-2:0], bit_in};
  end

  assign head = sreg[FRAME_BITS-1 -: HEAD_W];
  assign tail = sreg[TAIL_W-1:0];
endmodule

// File: rtl/spi_result_hold.sv
module spi_result_hold #(
  parameter int HEAD_W = 8,
  parameter int TAIL_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [HEAD_W-1:0] head,
  input  logic [TAIL_W-1:0] tail,
  output logic [TAIL_W-1:0] value,
  output logic              head_bad
);
  localparam logic [HEAD_W-1:0] FILLER = {HEAD_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value    <= '0;
      head_bad <= 1'b0;
    end else if (load) begin
      value    <= tail;
      head_bad <= (head != FILLER);
    end
  end
endmodule

// File: rtl/spi_press_reader.sv
module spi_press_reader #(
  parameter int HALF_DIV   = 4,
  parameter int NUM_BYTES  = 3,
  parameter int BYTE_W     = 8,
  parameter int PRES_W     = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [PRES_W-1:0] pressure,
  output logic              filler_err,
  output logic              sck,
  output logic              ss_n,
  output logic              mosi,
  input  logic              miso
);
  import spi_press_pkg::*;

  localparam int FRAME_BITS = NUM_BYTES * BYTE_W;
  localparam int BIT_CW     = $clog2(FRAME_BITS + 1);
  localparam logic [BIT_CW-1:0] LAST_BIT = BIT_CW'(FRAME_BITS - 1);

  rd_state_t         state;
  logic [BIT_CW-1:0] bits_done;
  logic              sck_q;
  logic              ss_q;
  logic              tick;
  logic              timer_run;
  logic              shift_en;
  logic              shift_clr;
  logic              load_res;
  logic [BYTE_W-1:0] head_byte;
  logic [PRES_W-1:0] tail_field;

  assign timer_run = (state == RD_SETUP) || (state == RD_HIGH) ||
                     (state == RD_LOW)   || (state == RD_HOLD);
  assign shift_clr = (state == RD_IDLE) && start;
  assign shift_en  = tick && ((state == RD_SETUP) || (state == RD_LOW));
  assign load_res  = tick && (state == RD_HOLD);

  spi_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (timer_run),
    .tick  (tick)
  );

  spi_rx_shift #(
    .FRAME_BITS (FRAME_BITS),
    .HEAD_W     (BYTE_W),
    .TAIL_W     (PRES_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (shift_clr),
    .shift_en (shift_en),
    .bit_in   (miso),
    .head     (head_byte),
    .tail     (tail_field)
  );

  spi_result_hold #(
    .HEAD_W (BYTE_W),
    .TAIL_W (PRES_W)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_res),
    .head     (head_byte),
    .tail     (tail_field),
    .value    (pressure),
    .head_bad (filler_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= RD_IDLE;
      sck_q     <= 1'b0;
      ss_q      <= 1'b1;
      bits_done <= '0;
    end else begin
      case (state)
        RD_IDLE: begin
          if (start) begin
            state     <= RD_SETUP;
            ss_q      <= 1'b0;
            bits_done <= '0;
          end
        end
        RD_SETUP, RD_LOW: begin
          if (tick) begin
            sck_q <= 1'b1;
            state <= RD_HIGH;
          end
        end
        RD_HIGH: begin
          if (tick) begin
            sck_q     <= 1'b0;
            bits_done <= bits_done + 1'b1;
            state     <= (bits_done == LAST_BIT) ? RD_HOLD : RD_LOW;
          end
        end
        RD_HOLD: begin
          if (tick) begin
            ss_q  <= 1'b1;
            state <= RD_VALID;
          end
        end
        RD_VALID: begin
          if (res_ready) state <= RD_IDLE;
        end
        default: state <= RD_IDLE;
      endcase
    end
  end

  assign sck       = sck_q;
  assign ss_n      = ss_q;
  assign mosi      = 1'b1;
  assign busy      = (state != RD_IDLE);
  assign res_valid = (state == RD_VALID);
endmodule

// File: rtl/spi_press_reader_chk.sv
module spi_press_reader_chk #(
  parameter int FRAME_BITS = 24,
  parameter int PRES_W     = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              res_valid,
  input logic              res_ready,
  input logic [PRES_W-1:0] pressure,
  input logic              filler_err,
  input logic              sck,
  input logic              ss_n
);
  logic       sck_d;
  logic [7:0] rises;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      rises <= '0;
    end else begin
      sck_d <= sck;
      if (ss_n)               rises <= '0;
      else if (sck && !sck_d) rises <= rises + 1'b1;
    end
  end

  AST_SCK_QUIET_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sck); // R2
  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ss_n) |-> (rises == 8'(FRAME_BITS))); // R2
  AST_VALID_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(res_valid) |-> $rose(ss_n)); // R7
  AST_RESULT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && busy && $stable(pressure) && $stable(filler_err))); // R7
  AST_FRAME_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_n |-> busy); // R1
  AST_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> (!res_valid && !busy)); // R7
endmodule

bind spi_press_reader spi_press_reader_chk #(
  .FRAME_BITS (NUM_BYTES * BYTE_W),
  .PRES_W     (PRES_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .pressure   (pressure),
  .filler_err (filler_err),
  .sck        (sck),
  .ss_n       (ss_n)
);

// File: tb/tb_spi_press_reader.sv
`timescale 1ns/1ps
module tb_spi_press_reader;
  localparam int D  = 3;
  localparam int FB = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        res_ready = 1'b0;
  logic        miso;
  logic        busy, res_valid, filler_err, sck, ss_n, mosi;
  logic [14:0] pressure;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  spi_press_reader #(.HALF_DIV(D)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .res_valid(res_valid), .res_ready(res_ready), .pressure(pressure),
    .filler_err(filler_err), .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso)
  );

  // slave model: next bit presented on each falling sck, first bit when selected
  logic [23:0] cur_frame = 24'h0;
  int          sidx = 0;
  always @(negedge ss_n) sidx = 0;
  always @(negedge sck) if (!ss_n) sidx = sidx + 1;
  always_comb miso = (sidx < FB) ? cur_frame[FB-1-sidx] : 1'b0;

  // behavioural reference timeline
  bit          m_act = 0, m_val = 0;
  int          m_n = 0;
  logic [14:0] m_p = '0;
  bit          m_e = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_val = 0; m_n = 0; m_p = '0; m_e = 0;
    end else if (m_act) begin
      m_n = m_n + 1;
      if (m_n == (2*FB+1)*D) begin
        m_act = 0; m_val = 1;
        m_p = cur_frame[14:0];
        m_e = (cur_frame[23:16] != 8'hFF);
      end
    end else if (m_val) begin
      if (res_ready) m_val = 0;
    end else if (start) begin
      m_act = 1; m_n = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_sck();
    if (!m_act || m_n < D || m_n >= 2*FB*D) return 1'b0;
    return (((m_n - D) / D) % 2) == 0;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(ss_n == !m_act, "R2/R3", "ss_n", ss_n, !m_act);
      chk(sck == exp_sck(), "R3", "sck", sck, exp_sck());
      chk(mosi == 1'b1, "R4", "mosi", mosi, 1);
      chk(busy == (m_act || m_val), "R1", "busy", busy, m_act || m_val);
      chk(res_valid == m_val, "R7", "res_valid", res_valid, m_val);
      if (m_val) begin
        chk(pressure == m_p, "R5", "pressure", pressure, m_p);
        chk(filler_err == m_e, "R6", "filler_err", filler_err, m_e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start = 1'b1; cyc(1); start = 1'b0;
  endtask

  task automatic run_frame(input logic [23:0] frm, input int stall,
                           input bit poke_mid, input bit start_on_accept);
    cur_frame = frm;
    pulse_start();
    if (poke_mid) begin cyc(10*D); pulse_start(); end
    while (!res_valid) cyc(1);
    if (stall > 0) begin
      start = 1'b1; cyc(stall); start = 1'b0;   // start while valid: ignored (R1)
    end
    res_ready = 1'b1;
    start = start_on_accept;
    cyc(1);
    res_ready = 1'b0; start = 1'b0;
    cyc(2);
  endtask

  initial begin
    #1;
    cyc(3);
    // R8: reset state, observed while reset is held
    chk(ss_n == 1'b1 && sck == 1'b0 && busy == 1'b0 && res_valid == 1'b0,
        "R8", "reset state", {ss_n, sck, busy, res_valid}, 4'b1000);
    rst_n = 1'b1;
    cyc(2);
    run_frame(24'hFF_1234, 0, 0, 0);   // R5 basic
    run_frame(24'hFF_FFFF, 3, 0, 0);   // R5: bit 15 dropped, R7 stall
    run_frame(24'hFF_5A5A, 0, 1, 0);   // R1: mid-frame start ignored
    run_frame(24'h7F_0001, 5, 0, 1);   // R6 bad filler, R1 start on accept ignored
    cyc(5);
    chk(busy == 1'b0 && ss_n == 1'b1, "R1", "start on accept ignored", {busy, ss_n}, 2'b01);
    run_frame(24'hFE_8000, 0, 0, 0);   // R6 single bit off, R5 top bit only
    run_frame(24'hFF_7FFF, 1, 0, 0);   // R5 full-scale
    cyc(5);
    chk(!busy && !res_valid, "R7", "idle after consume", {busy, res_valid}, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 20000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule